// File: doc/BRIEF.md
# Single-Bit Test-and-Modify Unit

This unit carries out the four single-bit operations of a classic CISC execute stage. An operation code chooses one of four actions: test a bit, clear it, toggle it or set it. It works on one bit of a destination operand, and a separate bit-number operand says which bit. The destination is either a data register, where any of 32 bits may be addressed, or a byte in memory, where only 8 bits may be addressed. The operand-kind input picks the modulus applied to the bit number. Every operation reports a zero condition taken from the tested bit before the operation changes it. Every operation also gives the updated destination, a write-back enable and a timing hint in half-cycles for the sequencer.

Operands come in on a valid/ready stream, and results go out on a second valid/ready stream through a single output register. When the downstream side lowers `out_ready`, the held result stays frozen. The unit then accepts a new operation only in a cycle where the held result is being taken. The throughput is one operation per cycle, and the latency is one cycle.

Top module: `bitsel_unit`

## Requirements
- R1: `in_op` encodes 2'b00 = test, 2'b01 = clear, 2'b10 = toggle, 2'b11 = set. With `in_is_mem` = 0 (register), the addressed bit is `in_bitnum[4:0]`.
- R2: With `in_is_mem` = 1 (memory byte), the addressed bit is `in_bitnum[2:0]`. Bit-number bits above the modulus are ignored, so 33 on a register and 9 on memory both address bit 1.
- R3: `out_zero` is 1 exactly when the addressed bit of the original destination was 0. This holds for all four operations.
- R4: Clear returns the destination with the addressed bit forced to 0. Toggle returns it with that bit inverted, and set returns it with that bit forced to 1. All other bits are unchanged.
- R5: Test returns the destination unchanged with `out_wb_en` = 0. Clear, toggle and set drive `out_wb_en` = 1.
- R6: For a memory destination, bits 31..8 of the result always equal bits 31..8 of the input destination.
- R7: `out_cycles` is 8 for clear and 4 for test, toggle and set. For a register destination, clear, toggle and set add 4 when the addressed bit is 16 or higher.
- R8: An operation accepted on a rising edge (`in_valid` and `in_ready` both high) is presented one cycle later with `out_valid` high. `in_ready` is high whenever the output register is empty or being drained. While `out_valid` is high and `out_ready` is low, all result outputs stay stable.
- R9: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set valid |
| in_ready | output | 1 | Unit can accept an operand set |
| in_op | input | 2 | Operation code (test/clear/toggle/set) |
| in_bitnum | input | 32 | Bit-number operand |
| in_dest | input | 32 | Destination operand value |
| in_is_mem | input | 1 | 1 = memory byte destination, 0 = data register |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts result |
| out_result | output | 32 | Updated destination |
| out_zero | output | 1 | Original addressed bit was 0 |
| out_wb_en | output | 1 | Destination must be written back |
| out_cycles | output | 4 | Timing hint in half-cycles |

## Verification
Directed operand sets cover bit 0 and bit 31, the half-word boundary at bits 15 and 16, and oversized bit numbers (33 on a register, 9 on memory). These show whether the modulus and the upper-half cost penalty are chosen by operand kind. Memory operands are given non-zero upper bytes, which exposes any change to bits outside the addressed byte. Each operation is run on destinations where the addressed bit is 0 and where it is 1, so that a zero flag taken after modification is told apart from one taken before. A long run of random operand sets is fed while `out_ready` is toggled at random, which tests the hold and acceptance rules under back-pressure.

// File: rtl/bitsel_pkg.sv
package bitsel_pkg;
  typedef enum logic [1:0] {
    BOP_TEST   = 2'b00,
    BOP_CLEAR  = 2'b01,
    BOP_TOGGLE = 2'b10,
    BOP_SET    = 2'b11
  } bop_e;

  localparam int unsigned REG_BITS  = 32;
  localparam int unsigned MEM_BITS  = 8;
  localparam int unsigned HINT_W    = 4;
endpackage

// File: rtl/bitsel_locate.sv
// Turns the bit-number operand into a one-hot mask, reduced modulo the
// operand width chosen by the destination kind.
module bitsel_locate #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MEM_W  = 8,
  localparam int unsigned IDX_W  = $clog2(DATA_W),
  localparam int unsigned MIDX_W = $clog2(MEM_W)
) (
  input  logic [DATA_W-1:0] bitnum,
  input  logic              is_mem,
  output logic [IDX_W-1:0]  index,
  output logic [DATA_W-1:0] mask,
  output logic              upper_half
);
  logic unused_hi;
  assign unused_hi = ^bitnum[DATA_W-1:IDX_W];

  always_comb begin
    if (is_mem) index = {{(IDX_W-MIDX_W){1'b0}}, bitnum[MIDX_W-1:0]};
    else        index = bitnum[IDX_W-1:0];
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_mask
    assign mask[b] = (index == IDX_W'(b));
  end

  assign upper_half = (index >= IDX_W'(DATA_W/2));
endmodule

// File: rtl/bitsel_alu.sv
// Per-bit modify network plus tested-bit extraction.
module bitsel_alu #(
  parameter int unsigned DATA_W = 32
) (
  input  bitsel_pkg::bop_e  op,
  input  logic [DATA_W-1:0] dest,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] result,
  output logic              zero,
  output logic              wb_en
);
  import bitsel_pkg::*;

  assign zero  = ~|(dest & mask);
  assign wb_en = (op != BOP_TEST);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    always_comb begin
      if (!mask[b]) begin
        result[b] = dest[b];
      end else begin
        unique case (op)
          BOP_CLEAR:  result[b] = 1'b0;
          BOP_TOGGLE: result[b] = ~dest[b];
          BOP_SET:    result[b] = 1'b1;
          default:    result[b] = dest[b];
        endcase
      end
    end
  end
endmodule

// File: rtl/bitsel_cost.sv
// Timing hint in half-cycles for the sequencer.
module bitsel_cost #(
  parameter int unsigned HINT_W     = 4,
  parameter int unsigned BASE_CLEAR = 8,
  parameter int unsigned BASE_OTHER = 4,
  parameter int unsigned UPPER_ADD  = 4
) (
  input  bitsel_pkg::bop_e  op,
  input  logic              is_mem,
  input  logic              upper_half,
  output logic [HINT_W-1:0] cycles
);
  import bitsel_pkg::*;

  logic [HINT_W-1:0] base;
  logic              penalty;

  always_comb begin
    base    = (op == BOP_CLEAR) ? HINT_W'(BASE_CLEAR) : HINT_W'(BASE_OTHER);
    penalty = !is_mem && upper_half && (op != BOP_TEST);
    cycles  = base + (penalty ? HINT_W'(UPPER_ADD) : '0);
  end
endmodule

// File: rtl/bitsel_unit.sv
module bitsel_unit #(
  parameter int unsigned DATA_W = bitsel_pkg::REG_BITS,
  parameter int unsigned MEM_W  = bitsel_pkg::MEM_BITS,
  parameter int unsigned HINT_W = bitsel_pkg::HINT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [DATA_W-1:0] in_bitnum,
  input  logic [DATA_W-1:0] in_dest,
  input  logic              in_is_mem,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_zero,
  output logic              out_wb_en,
  output logic [HINT_W-1:0] out_cycles
);
  import bitsel_pkg::*;

  localparam int unsigned IDX_W = $clog2(DATA_W);

  bop_e              op;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] mask;
  logic              upper;
  logic [DATA_W-1:0] alu_result;
  logic              alu_zero;
  logic              alu_wb;
  logic [HINT_W-1:0] cost;
  logic              accept;

  assign op = bop_e'(in_op);

  bitsel_locate #(.DATA_W(DATA_W), .MEM_W(MEM_W)) locate_i (
    .bitnum(in_bitnum), .is_mem(in_is_mem), .index(idx),
    .mask(mask), .upper_half(upper)
  );

  bitsel_alu #(.DATA_W(DATA_W)) alu_i (
    .op(op), .dest(in_dest), .mask(mask),
    .result(alu_result), .zero(alu_zero), .wb_en(alu_wb)
  );

  bitsel_cost #(.HINT_W(HINT_W)) cost_i (
    .op(op), .is_mem(in_is_mem), .upper_half(upper), .cycles(cost)
  );

  logic unused_idx;
  assign unused_idx = ^idx;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_zero   <= 1'b0;
      out_wb_en  <= 1'b0;
      out_cycles <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (accept) begin
        out_result <= alu_result;
        out_zero   <= alu_zero;
        out_wb_en  <= alu_wb;
        out_cycles <= cost;
      end
    end
  end

  // R8: stalled result is frozen
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) &&
      $stable(out_zero) && $stable(out_wb_en) && $stable(out_cycles));

  // R8: accepted operation appears next cycle
  a_r8_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R5: test neither changes nor requests a write
  a_r5_test_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == BOP_TEST |-> alu_result == in_dest && !alu_wb);

  // R6: memory upper bits pass through
  a_r6_mem_upper: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_is_mem |-> alu_result[DATA_W-1:MEM_W] == in_dest[DATA_W-1:MEM_W]);

  // R4: set never yields zero, clear never adds ones
  a_r4_set_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == BOP_SET |-> alu_result != '0);
  a_r4_clear_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == BOP_CLEAR |-> $countones(alu_result) <= $countones(in_dest));

  // R4/R3: a modifying op changes at most one bit
  a_r4_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $countones(alu_result ^ in_dest) <= 1);

  // R7: hint is one of the legal costs
  a_r7_hint_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_cycles == HINT_W'(4) || out_cycles == HINT_W'(8) ||
      out_cycles == HINT_W'(12));
endmodule

// File: tb/bitsel_unit_tb.sv
module bitsel_unit_tb_top;
  typedef struct {
    logic [31:0] res;
    logic        z;
    logic        wb;
    logic [3:0]  cyc;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'b00;
  logic [31:0] in_bitnum = '0;
  logic [31:0] in_dest = '0;
  logic        in_is_mem = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_result;
  logic        out_zero;
  logic        out_wb_en;
  logic [3:0]  out_cycles;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit stress = 0;
  exp_t sb[$];

  always #10 clk = ~clk;

  bitsel_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_bitnum(in_bitnum), .in_dest(in_dest),
    .in_is_mem(in_is_mem), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_zero(out_zero), .out_wb_en(out_wb_en),
    .out_cycles(out_cycles)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [1:0] op, input logic [31:0] bn,
                                 input logic [31:0] d, input logic mem, input string tag);
    exp_t e;
    int   k;
    k      = mem ? int'(bn % 8) : int'(bn % 32);
    e.z    = (d[k] == 1'b0);
    e.res  = d;
    if (op == 2'd1) e.res[k] = 1'b0;
    if (op == 2'd2) e.res[k] = ~d[k];
    if (op == 2'd3) e.res[k] = 1'b1;
    e.wb   = (op != 2'd0);
    e.cyc  = (op == 2'd1) ? 4'd8 : 4'd4;
    if (!mem && op != 2'd0 && k >= 16) e.cyc = e.cyc + 4'd4;
    e.tag  = tag;
    return e;
  endfunction

  task automatic send(input logic [1:0] op, input logic [31:0] bn,
                      input logic [31:0] d, input logic mem, input string tag);
    in_valid  = 1'b1;
    in_op     = op;
    in_bitnum = bn;
    in_dest   = d;
    in_is_mem = mem;
    forever begin
      @(negedge clk);
      if (in_ready) begin
        sb.push_back(model(op, bn, d, mem, tag));
        @(posedge clk); #1;
        break;
      end
      @(posedge clk); #1;
    end
  endtask

  // back-pressure generator
  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = stress ? ($urandom % 3 != 0) : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    logic        held = 0;
    logic [31:0] h_res;
    logic        h_z, h_wb;
    logic [3:0]  h_cyc;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (held) begin
          check(out_result == h_res && out_zero == h_z && out_wb_en == h_wb &&
                out_cycles == h_cyc, "R8", "stall hold", out_result, h_res);
        end
        if (out_ready) begin
          held = 0;
          if (sb.size() == 0) begin
            check(0, "R8", "unexpected output", out_result, 32'h0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(out_result == e.res, e.tag, "result", out_result, e.res);
            check(out_zero == e.z, "R3", "zero", 32'(out_zero), 32'(e.z));
            check(out_wb_en == e.wb, "R5", "wb_en", 32'(out_wb_en), 32'(e.wb));
            check(out_cycles == e.cyc, "R7", "cycles", 32'(out_cycles), 32'(e.cyc));
          end
        end else begin
          held = 1;
          h_res = out_result; h_z = out_zero; h_wb = out_wb_en; h_cyc = out_cycles;
        end
      end else begin
        held = 0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", sb.size());
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R9", "reset out_valid", 32'(out_valid), 32'h0);
    check(in_ready == 1'b1, "R9", "reset in_ready", 32'(in_ready), 32'h1);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: register bit numbers across the word
    send(2'd0, 32'd0,  32'h0000_0001, 1'b0, "R1");
    send(2'd0, 32'd31, 32'h0000_0000, 1'b0, "R1");
    send(2'd1, 32'd15, 32'hFFFF_FFFF, 1'b0, "R4");
    send(2'd1, 32'd16, 32'hFFFF_FFFF, 1'b0, "R4");
    send(2'd2, 32'd31, 32'h8000_0000, 1'b0, "R4");
    send(2'd2, 32'd3,  32'h0000_0000, 1'b0, "R4");
    send(2'd3, 32'd20, 32'h0000_0000, 1'b0, "R4");
    send(2'd3, 32'd7,  32'h0000_0080, 1'b0, "R4");
    // R2: modulus by operand kind
    send(2'd3, 32'd33, 32'h0000_0000, 1'b0, "R2");
    send(2'd3, 32'd9,  32'h0000_0000, 1'b1, "R2");
    send(2'd1, 32'd31, 32'hFFFF_FFFF, 1'b1, "R2");
    // R6: memory upper bits untouched, no high-half penalty
    send(2'd2, 32'd20, 32'hA5C3_3C00, 1'b1, "R6");
    send(2'd1, 32'd16, 32'h1234_56FF, 1'b1, "R6");
    // R5: test leaves value
    send(2'd0, 32'd17, 32'hDEAD_BEEF, 1'b0, "R5");

    stress = 1;
    for (int i = 0; i < 400; i++) begin
      send(2'($urandom), $urandom, $urandom, 1'($urandom), "R4");
      if ($urandom % 5 == 0) begin
        in_valid = 1'b0;
        @(posedge clk); #1;
      end
    end
    in_valid = 1'b0;
    stress = 0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(sb.size() == 0, "R8", "all results delivered", sb.size(), 32'h0);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule